// File: doc/BRIEF.md
# Distance-to-tone generator with transmit gating

This block turns a 6-bit ranging code, measured once per frame under the front of a walking aid's sole, into a square-wave audio tone whose pitch climbs as the measured gap to the ground grows. A phase accumulator produces the tone. Its increment is a fixed offset plus a linear step per code level, so the lowest code still gives an audible tone of roughly 100 Hz. The top of the scale lies one step above code 63, near 5 kHz.

Two echo flags choose the audio behaviour:

- A strong close echo (`contact_echo`) means the foot is on the ground, and the output is silent.
- An echo inside the ranging window (`range_echo`) gives the variable tone.
- When neither echo is present, a fixed warning tone plays at the full-scale pitch.

The same close-echo flag gates a transmit enable. The enable rises only after the foot has stayed lifted across two frame-marker rising edges. It drops in the same cycle that ground contact is seen.

The audio policy is a three-state machine:

- **AUD_QUIET** is the reset state.
- **AUD_TRACK** is the variable tone.
- **AUD_ALARM** is the warning tone.

Its transitions are *go_quiet* (close echo), *go_track* (range echo without close echo) and *go_alarm* (no echo). It re-evaluates them on every clock.

The transmit qualifier is a second three-state machine:

- **TX_GROUNDED** is the reset state.
- **TX_LIFT1** is reached after one lifted frame.
- **TX_ARMED** is the state in which transmit is on.

Its transitions are *lift_step* (a frame edge while lifted), *hold* (no edge), and *touch_down*, which returns to TX_GROUNDED from any state.

Top module: `dist_tone_gen`

## Requirements
- R1: When `contact_echo` is 1 at a clock edge, the policy enters AUD_QUIET and `tone_out` is 0 from that edge on, with the phase accumulator cleared.
- R2: With `contact_echo` 0 and `range_echo` 1, the tone period is 65536/(6 + 5*code) clock cycles, within one cycle. This uses the default parameters: a 16-bit accumulator, a 1 MHz clock, 100 Hz and 5 kHz.
- R3: With both echo flags 0, the warning tone uses increment 6 + 5*64 = 326. That is a period of about 201 cycles, shorter than the period for any code.
- R4: The pitch rises strictly with the code. A higher code always gives a shorter period.
- R5: `contact_echo` has priority over `range_echo`. With both set, the output is silent.
- R6: While `contact_echo` is 1, `tx_en` is 0 in the same cycle, whatever `frame_tick` does, and the qualifier returns to TX_GROUNDED.
- R7: With `contact_echo` 0, `tx_en` rises after the second rising edge of `frame_tick`, and not after the first.
- R8: A `frame_tick` held high for many cycles counts as a single rising edge.
- R9: During and right after reset, `tone_out` and `tx_en` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (1 MHz by default) |
| rst_n | input | 1 | Asynchronous reset, active low |
| dist_code | input | 6 | Ranging code, 0 = nearest, 63 = farthest |
| contact_echo | input | 1 | Strong close echo: foot on the ground |
| range_echo | input | 1 | Echo found inside the ranging window |
| frame_tick | input | 1 | Frame marker, one rising edge per measurement frame |
| tone_out | output | 1 | Square-wave audio tone |
| tx_en | output | 1 | Transmitter enable |

## Verification
On every cycle the assertions check that:
- the output falls silent one edge after ground contact;
- the enable is low whenever contact is present;
- any rise of the enable is preceded by a lifted cycle and by a fresh frame-marker edge.

The pitch values, the strict ordering of pitch across codes and the warning tone's position above the top code can only be shown by the bench. It measures periods between tone rising edges over whole scenarios. The count of two frames needed before transmit is also shown only by the bench.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // Audio policy states
    typedef enum logic [1:0] {
        AUD_QUIET = 2'd0,
        AUD_TRACK = 2'd1,
        AUD_ALARM = 2'd2
    } aud_state_e;

    // Transmit lift qualifier states
    typedef enum logic [1:0] {
        TX_GROUNDED = 2'd0,
        TX_LIFT1    = 2'd1,
        TX_ARMED    = 2'd2
    } tx_state_e;

endpackage

// File: rtl/dtg_audio_fsm.sv
module dtg_audio_fsm
    import dtg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       contact_echo,
    input  logic       range_echo,
    output aud_state_e state_o,
    output logic       run_o,
    output logic       alarm_o
);

    aud_state_e state_q;
    aud_state_e state_d;

    // The close echo wins over the range echo
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AUD_QUIET: begin
                if (contact_echo)    state_d = AUD_QUIET;   // go_quiet
                else if (range_echo) state_d = AUD_TRACK;   // go_track
                else                 state_d = AUD_ALARM;   // go_alarm
            end
            AUD_TRACK: begin
                if (contact_echo)    state_d = AUD_QUIET;
                else if (range_echo) state_d = AUD_TRACK;
                else                 state_d = AUD_ALARM;
            end
            AUD_ALARM: begin
                if (contact_echo)    state_d = AUD_QUIET;
                else if (range_echo) state_d = AUD_TRACK;
                else                 state_d = AUD_ALARM;
            end
            default:                 state_d = AUD_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AUD_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        run_o   = 1'b0;
        alarm_o = 1'b0;
        unique case (state_q)
            AUD_QUIET: begin
                run_o   = 1'b0;
                alarm_o = 1'b0;
            end
            AUD_TRACK: begin
                run_o   = 1'b1;
                alarm_o = 1'b0;
            end
            AUD_ALARM: begin
                run_o   = 1'b1;
                alarm_o = 1'b1;
            end
            default: begin
                run_o   = 1'b0;
                alarm_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/dtg_phase_nco.sv
module dtg_phase_nco #(
    parameter int ACC_W      = 16,
    parameter int CODE_W     = 6,
    parameter int OFFSET_INC = 6,
    parameter int STEP_INC   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              alarm,
    input  logic [CODE_W-1:0] code,
    output logic              wave_o
);

    localparam int LEVELS   = 1 << CODE_W;
    localparam int FULL_INC = OFFSET_INC + LEVELS * STEP_INC;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] step_w;

    // Linear code-to-increment map with a fixed floor
    always_comb begin
        if (alarm) step_w = ACC_W'(FULL_INC);
        else       step_w = ACC_W'(OFFSET_INC) + ACC_W'(code) * ACC_W'(STEP_INC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc_q <= '0;
        else if (run) acc_q <= acc_q + step_w;
        else          acc_q <= '0;
    end

    assign wave_o = run & acc_q[ACC_W-1];

endmodule

// File: rtl/dtg_lift_qual.sv
module dtg_lift_qual
    import dtg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      contact_echo,
    input  logic      frame_tick,
    output tx_state_e state_o,
    output logic      tx_en_o
);

    tx_state_e state_q;
    tx_state_e state_d;
    logic      tick_prev_q;
    logic      tick_edge;

    assign tick_edge = frame_tick & ~tick_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_prev_q <= 1'b0;
        else        tick_prev_q <= frame_tick;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_GROUNDED: begin
                if (contact_echo)   state_d = TX_GROUNDED;  // touch_down
                else if (tick_edge) state_d = TX_LIFT1;     // lift_step
                else                state_d = TX_GROUNDED;  // hold
            end
            TX_LIFT1: begin
                if (contact_echo)   state_d = TX_GROUNDED;
                else if (tick_edge) state_d = TX_ARMED;
                else                state_d = TX_LIFT1;
            end
            TX_ARMED: begin
                if (contact_echo)   state_d = TX_GROUNDED;
                else                state_d = TX_ARMED;
            end
            default:                state_d = TX_GROUNDED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_GROUNDED;
        else        state_q <= state_d;
    end

    // Contact masks the enable in the same cycle
    always_comb begin
        tx_en_o = 1'b0;
        unique case (state_q)
            TX_GROUNDED: tx_en_o = 1'b0;
            TX_LIFT1:    tx_en_o = 1'b0;
            TX_ARMED:    tx_en_o = ~contact_echo;
            default:     tx_en_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/dist_tone_gen.sv
module dist_tone_gen
    import dtg_pkg::*;
#(
    parameter int CLK_HZ  = 1_000_000,
    parameter int FMIN_HZ = 100,
    parameter int FMAX_HZ = 5000,
    parameter int ACC_W   = 16,
    parameter int CODE_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] dist_code,
    input  logic              contact_echo,
    input  logic              range_echo,
    input  logic              frame_tick,
    output logic              tone_out,
    output logic              tx_en
);

    localparam longint SPAN   = longint'(1) << ACC_W;
    localparam longint LEVELS = longint'(1) << CODE_W;
    localparam int     OFS    = int'((longint'(FMIN_HZ) * SPAN) / longint'(CLK_HZ));
    localparam int     STP    = int'((longint'(FMAX_HZ - FMIN_HZ) * SPAN)
                                     / (longint'(CLK_HZ) * LEVELS));

    aud_state_e aud_state;
    tx_state_e  tx_state;
    logic       nco_run;
    logic       nco_alarm;

    dtg_audio_fsm u_policy (
        .clk          (clk),
        .rst_n        (rst_n),
        .contact_echo (contact_echo),
        .range_echo   (range_echo),
        .state_o      (aud_state),
        .run_o        (nco_run),
        .alarm_o      (nco_alarm)
    );

    dtg_phase_nco #(
        .ACC_W      (ACC_W),
        .CODE_W     (CODE_W),
        .OFFSET_INC (OFS),
        .STEP_INC   (STP)
    ) u_nco (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (nco_run),
        .alarm  (nco_alarm),
        .code   (dist_code),
        .wave_o (tone_out)
    );

    dtg_lift_qual u_lift (
        .clk          (clk),
        .rst_n        (rst_n),
        .contact_echo (contact_echo),
        .frame_tick   (frame_tick),
        .state_o      (tx_state),
        .tx_en_o      (tx_en)
    );

endmodule

// File: rtl/dtg_chk.sv
module dtg_chk (
    input logic clk,
    input logic rst_n,
    input logic contact_echo,
    input logic range_echo,
    input logic frame_tick,
    input logic tone_out,
    input logic tx_en
);

    // R1
    quiet_after_contact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        contact_echo |=> !tone_out);

    // R6
    tx_masked_by_contact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        contact_echo |-> !tx_en);

    // R7
    tx_rise_when_lifted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (!contact_echo && !$past(contact_echo)));

    // R8
    tx_rise_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> ($past(frame_tick) && !$past(frame_tick, 2)));

endmodule

bind dist_tone_gen dtg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .contact_echo (contact_echo),
    .range_echo   (range_echo),
    .frame_tick   (frame_tick),
    .tone_out     (tone_out),
    .tx_en        (tx_en)
);

// File: tb/dist_tone_gen_bench.sv
module dist_tone_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SPAN       = 65536;
    localparam int OFS        = 6;
    localparam int STP        = 5;
    localparam int FULL       = OFS + 64 * STP;
    localparam int LIMIT      = 40000;

    typedef struct packed {
        logic       contact;
        logic       rng;
        logic [5:0] code;
    } vec_t;

    // contact, range, code
    localparam vec_t VECS [7] = '{
        '{1'b1, 1'b0, 6'd10},   // R1 silent
        '{1'b0, 1'b1, 6'd0},    // R2 lowest
        '{1'b0, 1'b1, 6'd1},    // R2
        '{1'b0, 1'b1, 6'd33},   // R2
        '{1'b0, 1'b1, 6'd63},   // R2 top
        '{1'b0, 1'b0, 6'd20},   // R3 warning
        '{1'b1, 1'b1, 6'd63}    // R5 priority
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] dist_code = '0;
    logic       contact_echo = 1'b0;
    logic       range_echo = 1'b0;
    logic       frame_tick = 1'b0;
    logic       tone_out;
    logic       tx_en;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dist_tone_gen u_dist_tone_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .dist_code    (dist_code),
        .contact_echo (contact_echo),
        .range_echo   (range_echo),
        .frame_tick   (frame_tick),
        .tone_out     (tone_out),
        .tx_en        (tx_en)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_total++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(output int per, output bit ok);
        bit prev;
        bit cur;
        bit found;
        per   = 0;
        ok    = 0;
        found = 0;
        prev  = tone_out;
        cur   = tone_out;
        for (int n = 0; n < LIMIT && !found; n++) begin
            @(negedge clk);
            cur = tone_out;
            if (!prev && cur) found = 1;
            prev = cur;
        end
        if (found) begin
            for (int n = 1; n <= LIMIT && !ok; n++) begin
                @(negedge clk);
                cur = tone_out;
                if (!prev && cur) begin
                    per = n;
                    ok  = 1;
                end
                prev = cur;
            end
        end
    endtask

    task automatic tick_pulse();
        @(negedge clk) frame_tick = 1'b1;
        @(negedge clk) frame_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_period(input int inc, input string req, output int per);
        bit ok;
        int lo;
        measure(per, ok);
        lo = SPAN / inc;
        check(ok && per >= lo && per <= lo + 1, req, per, lo);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_fail++;
            n_total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int p;
        int p62;
        int p63;
        int pal;
        int highs;

        // R9 reset state
        repeat (3) @(negedge clk);
        check(tone_out == 1'b0, "R9", int'(tone_out), 0);
        check(tx_en == 1'b0, "R9", int'(tx_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tone_out == 1'b0, "R9", int'(tone_out), 0);

        // Table walk
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            contact_echo = VECS[i].contact;
            range_echo   = VECS[i].rng;
            dist_code    = VECS[i].code;
            if (VECS[i].contact) begin
                @(negedge clk);
                highs = 0;
                for (int k = 0; k < 500; k++) begin
                    @(negedge clk);
                    if (tone_out) highs++;
                end
                check(highs == 0, VECS[i].rng ? "R5" : "R1", highs, 0);
            end else if (VECS[i].rng) begin
                check_period(OFS + STP * int'(VECS[i].code), "R2", p);
            end else begin
                check_period(FULL, "R3", p);
            end
        end

        // R4 ordering, R3 above the top code
        @(negedge clk);
        contact_echo = 1'b0;
        range_echo   = 1'b1;
        dist_code    = 6'd62;
        check_period(OFS + STP * 62, "R2", p62);
        @(negedge clk) dist_code = 6'd63;
        check_period(OFS + STP * 63, "R2", p63);
        check(p62 > p63, "R4", p63, p62);
        @(negedge clk) range_echo = 1'b0;
        check_period(FULL, "R3", pal);
        check(p63 > pal, "R3", pal, p63);

        // R6 contact blocks transmit whatever the frame marker does
        @(negedge clk);
        contact_echo = 1'b1;
        range_echo   = 1'b1;
        repeat (3) tick_pulse();
        check(tx_en == 1'b0, "R6", int'(tx_en), 0);

        // R7 two lifted frames
        @(negedge clk) contact_echo = 1'b0;
        tick_pulse();
        check(tx_en == 1'b0, "R7", int'(tx_en), 0);
        tick_pulse();
        check(tx_en == 1'b1, "R7", int'(tx_en), 1);

        // R6 immediate drop on contact
        @(negedge clk) contact_echo = 1'b1;
        #1;
        check(tx_en == 1'b0, "R6", int'(tx_en), 0);
        @(negedge clk) contact_echo = 1'b0;
        @(negedge clk);
        check(tx_en == 1'b0, "R6", int'(tx_en), 0);

        // R8 level-held marker is one edge
        @(negedge clk) frame_tick = 1'b1;
        repeat (30) @(negedge clk);
        check(tx_en == 1'b0, "R8", int'(tx_en), 0);
        frame_tick = 1'b0;
        tick_pulse();
        check(tx_en == 1'b1, "R8", int'(tx_en), 1);

        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule